// File: doc/BRIEF.md
# Interrupt Acceptance Flag Sequencer

This block runs the state bookkeeping that a 16-bit processor core performs once it has chosen to take an interrupt. The core presents one accepted request as a single strobe. The strobe carries a source class, a software interrupt marker with its number, and a 3-bit priority level. The core also presents its current stack-select flag, its current interrupt priority level, the flag word to preserve and the program counter.

The block then emits up to three stack write beats and ends with a one-cycle done pulse. The done pulse carries the new stack-select flag, the cleared interrupt-enable and debug flags, and the new priority level. The block chooses the target stack on its own: the interrupt stack, or the stack the core is already using.

A dedicated non-maskable interrupt pin is synchronized inside the block. Only a high-to-low transition on it raises a request. That request is held until the sequencer is free, and it is served ahead of any request from the core. Vector fetch, arbitration among maskable sources and the datapath remain in the core.

Top module: `irq_accept_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and both `stk_wr` and `seq_done` are 0.
- R2: A falling edge on `nmi_pin` starts one sequence with `new_ipl` = 7 and `new_u` = 0, writing to the interrupt stack (`stk_user` = 0), whatever `cur_u` and `cur_ipl` are. A rising edge and a held low level start nothing.
- R3: A low pulse on `nmi_pin` lasting two clock periods is enough to produce exactly one non-maskable sequence, even though the pin returns high before that sequence starts.
- R4: A saving sequence writes on the three cycles right after acceptance. The slots are, in order, 0 (the flag word from `flg_in`), 1 (`pc_in[15:0]`) and 2 (`pc_in[19:16]` zero-extended to 16 bits). `seq_done` is high on the cycle after slot 2.
- R5: Except in the case covered by R6, every saving sequence uses `stk_user` = 0 and reports `new_u` = 0.
- R6: A request with `req_swint` = 1 and `req_swnum` >= 32 writes to the stack that `cur_u` selects (`stk_user` = `cur_u`) and reports `new_u` = `cur_u`.
- R7: `new_i` and `new_d` are 0 whenever `seq_done` is high.
- R8: `req_class` encodes the new level: 1 forces `new_ipl` to 7, 2 keeps `cur_ipl`, and 3 (maskable) loads `req_prio`.
- R9: Class 0 (reset) makes no stack writes. It gives `seq_done` on the cycle after acceptance, with `new_u` = 0 and `new_ipl` = 0.
- R10: `req_ready` is 0 from the acceptance edge through the `seq_done` cycle. A request presented in that window is dropped and starts no later sequence once it is withdrawn.
- R11: While a non-maskable request is pending, `req_ready` is 0. When the block goes idle with both that request and a core request present, the non-maskable sequence runs first and the core request is accepted on the cycle after its `seq_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_pin | input | 1 | Raw non-maskable interrupt pin, idle high |
| req_valid | input | 1 | Core presents an accepted interrupt |
| req_ready | output | 1 | Block is idle and no non-maskable request is pending |
| req_class | input | 2 | 0 reset, 1 force level 7, 2 keep level, 3 maskable |
| req_swint | input | 1 | Request comes from a software interrupt instruction |
| req_swnum | input | 6 | Software interrupt number |
| req_prio | input | 3 | Priority level of a maskable request |
| cur_u | input | 1 | Current stack-select flag (1 = user stack) |
| cur_ipl | input | 3 | Current interrupt priority level |
| flg_in | input | 16 | Flag word to save |
| pc_in | input | 20 | Program counter to save |
| stk_wr | output | 1 | Stack write strobe |
| stk_user | output | 1 | Target stack: 0 interrupt stack, 1 user stack |
| stk_slot | output | 2 | Beat index: 0 flags, 1 PC low, 2 PC high |
| stk_wdata | output | 16 | Stack write data |
| new_u | output | 1 | Stack-select flag after acceptance |
| new_i | output | 1 | Interrupt-enable flag after acceptance |
| new_d | output | 1 | Debug flag after acceptance |
| new_ipl | output | 3 | Priority level after acceptance |
| seq_done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The two functions that can meet are the pin edge detector and the core request port. The collision is provoked by letting a falling edge reach the pending latch during a busy sequence while a second core request is held valid. When the block turns idle, both requests compete in the same cycle. The bench judges the outcome by order: the next done pulse must carry level 7 on the interrupt stack, and the one after it must carry the held request's own priority.

// File: rtl/irq_accept_pkg.sv
// Shared types for the interrupt acceptance sequencer.
// Assumes a 2-bit source class supplied by the core's arbitration logic.
package irq_accept_pkg;

    typedef enum logic [1:0] {
        CLS_RESET = 2'd0,
        CLS_LVL7  = 2'd1,
        CLS_KEEP  = 2'd2,
        CLS_MASK  = 2'd3
    } src_class_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FLG,
        ST_PCL,
        ST_PCH,
        ST_FIN
    } seq_state_e;

    localparam logic [1:0] SLOT_FLG = 2'd0;
    localparam logic [1:0] SLOT_PCL = 2'd1;
    localparam logic [1:0] SLOT_PCH = 2'd2;

endpackage

// File: rtl/nmi_edge_detect.sv
// Synchronizes the raw non-maskable pin, detects a high-to-low transition and
// holds a pending request until the sequencer takes it.
// Assumes the pin idles high; a new edge on the take cycle re-arms the latch.
module nmi_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic take,
    output logic pending
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] sync_q;
    logic         last_q;
    logic         pend_q;
    logic         fall;

    // Sync chain plus one history flop, all idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[MSB-1:0], pin};
            last_q <= sync_q[MSB];
        end
    end

    // A high-to-low step on the synchronized level.
    always_comb fall = last_q & ~sync_q[MSB];

    // Pending latch: set by an edge, cleared when taken.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= fall | (pend_q & ~take);
    end

    assign pending = pend_q;
endmodule

// File: rtl/accept_policy.sv
// Decides the new priority level, the stack choice and whether any state is
// saved, for the request about to be taken. Purely combinational.
// Assumes is_nmi overrides the class fields.
module accept_policy
    import irq_accept_pkg::*;
#(
    parameter int IPL_W        = 3,
    parameter int SWNUM_W      = 6,
    parameter int SW_KEEP_BASE = 32
) (
    input  logic               is_nmi,
    input  src_class_e         cls,
    input  logic               swint,
    input  logic [SWNUM_W-1:0] swnum,
    input  logic [IPL_W-1:0]   prio,
    input  logic               cur_u,
    input  logic [IPL_W-1:0]   cur_ipl,
    output logic [IPL_W-1:0]   nxt_ipl,
    output logic               nxt_u,
    output logic               save_en
);
    localparam logic [SWNUM_W-1:0] KEEP_BASE = SWNUM_W'(SW_KEEP_BASE);

    logic keep_stack;

    // High-numbered software interrupts stay on the current stack.
    always_comb begin
        keep_stack = ~is_nmi & (cls != CLS_RESET) & swint & (swnum >= KEEP_BASE);
        nxt_u      = keep_stack ? cur_u : 1'b0;
        save_en    = is_nmi | (cls != CLS_RESET);
    end

    // Per-class priority level table.
    always_comb begin
        if (is_nmi) begin
            nxt_ipl = '1;
        end else begin
            unique case (cls)
                CLS_RESET: nxt_ipl = '0;
                CLS_LVL7:  nxt_ipl = '1;
                CLS_KEEP:  nxt_ipl = cur_ipl;
                default:   nxt_ipl = prio;
            endcase
        end
    end
endmodule

// File: rtl/irq_accept_seq.sv
// Interrupt acceptance sequencer: takes one request (pin edge first), writes
// the flag word and program counter to a stack port, then reports new flags.
// Assumes the core holds off vector fetch until seq_done and that
// DATA_W < PC_W <= 2*DATA_W.
module irq_accept_seq
    import irq_accept_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int PC_W         = 20,
    parameter int IPL_W        = 3,
    parameter int SWNUM_W      = 6,
    parameter int SW_KEEP_BASE = 32,
    parameter int NMI_SYNC     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nmi_pin,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_class,
    input  logic               req_swint,
    input  logic [SWNUM_W-1:0] req_swnum,
    input  logic [IPL_W-1:0]   req_prio,
    input  logic               cur_u,
    input  logic [IPL_W-1:0]   cur_ipl,
    input  logic [DATA_W-1:0]  flg_in,
    input  logic [PC_W-1:0]    pc_in,
    output logic               stk_wr,
    output logic               stk_user,
    output logic [1:0]         stk_slot,
    output logic [DATA_W-1:0]  stk_wdata,
    output logic               new_u,
    output logic               new_i,
    output logic               new_d,
    output logic [IPL_W-1:0]   new_ipl,
    output logic               seq_done
);
    localparam int HI_PAD = 2 * DATA_W - PC_W;

    seq_state_e           state_q;
    logic                 nmi_pend;
    logic                 is_idle;
    logic                 take_nmi;
    logic                 take_req;
    logic [IPL_W-1:0]     nxt_ipl;
    logic                 nxt_u;
    logic                 save_en;
    logic [DATA_W-1:0]    flg_q;
    logic [PC_W-1:0]      pc_q;
    logic                 u_q;
    logic [IPL_W-1:0]     ipl_q;

    nmi_edge_detect #(.SYNC_STAGES(NMI_SYNC)) u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (nmi_pin),
        .take    (take_nmi),
        .pending (nmi_pend)
    );

    accept_policy #(
        .IPL_W       (IPL_W),
        .SWNUM_W     (SWNUM_W),
        .SW_KEEP_BASE(SW_KEEP_BASE)
    ) u_policy (
        .is_nmi  (nmi_pend),
        .cls     (src_class_e'(req_class)),
        .swint   (req_swint),
        .swnum   (req_swnum),
        .prio    (req_prio),
        .cur_u   (cur_u),
        .cur_ipl (cur_ipl),
        .nxt_ipl (nxt_ipl),
        .nxt_u   (nxt_u),
        .save_en (save_en)
    );

    // Admission: a pending pin request wins over the core port.
    always_comb begin
        is_idle   = (state_q == ST_IDLE);
        take_nmi  = is_idle & nmi_pend;
        take_req  = is_idle & ~nmi_pend & req_valid;
        req_ready = is_idle & ~nmi_pend;
    end

    // Sequence state and capture of the saved context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            flg_q   <= '0;
            pc_q    <= '0;
            u_q     <= 1'b0;
            ipl_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (take_nmi || take_req) begin
                        flg_q   <= flg_in;
                        pc_q    <= pc_in;
                        u_q     <= nxt_u;
                        ipl_q   <= nxt_ipl;
                        state_q <= save_en ? ST_FLG : ST_FIN;
                    end
                end
                ST_FLG:  state_q <= ST_PCL;
                ST_PCL:  state_q <= ST_PCH;
                ST_PCH:  state_q <= ST_FIN;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Stack beat decode from the current state.
    always_comb begin
        stk_wr    = 1'b1;
        stk_slot  = SLOT_FLG;
        stk_wdata = flg_q;
        unique case (state_q)
            ST_FLG: ;
            ST_PCL: begin
                stk_slot  = SLOT_PCL;
                stk_wdata = pc_q[DATA_W-1:0];
            end
            ST_PCH: begin
                stk_slot  = SLOT_PCH;
                stk_wdata = {{HI_PAD{1'b0}}, pc_q[PC_W-1:DATA_W]};
            end
            default: stk_wr = 1'b0;
        endcase
    end

    assign stk_user = u_q;
    assign seq_done = (state_q == ST_FIN);
    assign new_u    = u_q;
    assign new_i    = 1'b0;
    assign new_d    = 1'b0;
    assign new_ipl  = ipl_q;
endmodule

// File: rtl/irq_accept_chk.sv
// Protocol checker for the interrupt acceptance sequencer, bound to its top.
// Assumes it only sees top-level ports.
module irq_accept_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [1:0] req_class,
    input logic       stk_wr,
    input logic [1:0] stk_slot,
    input logic       seq_done
);
    // R4
    start_flg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_class != 2'd0) |=> (stk_wr && stk_slot == 2'd0));
    // R4
    flg_then_pcl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_wr && stk_slot == 2'd0) |=> (stk_wr && stk_slot == 2'd1));
    // R4
    pcl_then_pch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_wr && stk_slot == 2'd1) |=> (stk_wr && stk_slot == 2'd2));
    // R4
    pch_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_wr && stk_slot == 2'd2) |=> (seq_done && !stk_wr));
    // R9
    reset_no_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_class == 2'd0) |=> (seq_done && !stk_wr));
    // R10
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_wr || seq_done) |-> !req_ready);
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);
endmodule

bind irq_accept_seq irq_accept_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_class (req_class),
    .stk_wr    (stk_wr),
    .stk_slot  (stk_slot),
    .seq_done  (seq_done)
);

// File: tb/tb_irq_accept_seq.sv
`timescale 1ns/1ps
module tb_irq_accept_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_pin = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_class = 2'd0;
    logic        req_swint = 1'b0;
    logic [5:0]  req_swnum = 6'd0;
    logic [2:0]  req_prio = 3'd0;
    logic        cur_u = 1'b0;
    logic [2:0]  cur_ipl = 3'd0;
    logic [15:0] flg_in = 16'h0;
    logic [19:0] pc_in = 20'h0;
    logic        stk_wr, stk_user, new_u, new_i, new_d, seq_done;
    logic [1:0]  stk_slot;
    logic [15:0] stk_wdata;
    logic [2:0]  new_ipl;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_accept_seq dut (.*);

    typedef struct packed {
        logic [1:0] cls;
        logic       swint;
        logic [5:0] num;
        logic [2:0] prio;
        logic       u;
        logic [2:0] ipl;
        logic       e_save;
        logic       e_sel;
        logic [2:0] e_ipl;
    } vec_t;

    // class, swint, num, prio, cur_u, cur_ipl -> save, stack/new_u, new_ipl
    localparam vec_t VECS [10] = '{
        '{2'd3, 1'b0, 6'd0,  3'd3, 1'b1, 3'd5, 1'b1, 1'b0, 3'd3},
        '{2'd3, 1'b0, 6'd0,  3'd6, 1'b0, 3'd0, 1'b1, 1'b0, 3'd6},
        '{2'd1, 1'b0, 6'd0,  3'd1, 1'b1, 3'd2, 1'b1, 1'b0, 3'd7},
        '{2'd2, 1'b0, 6'd0,  3'd2, 1'b1, 3'd4, 1'b1, 1'b0, 3'd4},
        '{2'd2, 1'b1, 6'd40, 3'd0, 1'b1, 3'd1, 1'b1, 1'b1, 3'd1},
        '{2'd2, 1'b1, 6'd31, 3'd0, 1'b1, 3'd6, 1'b1, 1'b0, 3'd6},
        '{2'd2, 1'b1, 6'd32, 3'd0, 1'b0, 3'd3, 1'b1, 1'b0, 3'd3},
        '{2'd2, 1'b1, 6'd63, 3'd0, 1'b1, 3'd7, 1'b1, 1'b1, 3'd7},
        '{2'd0, 1'b0, 6'd0,  3'd4, 1'b1, 3'd5, 1'b0, 1'b0, 3'd0},
        '{2'd3, 1'b1, 6'd50, 3'd2, 1'b1, 3'd0, 1'b1, 1'b1, 3'd2}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Present one request at a negedge; returns one negedge later.
    task automatic drive(input vec_t v, input logic [15:0] f, input logic [19:0] p);
        chk("R10", "ready before drive", {31'd0, req_ready}, 32'd1);
        req_class = v.cls; req_swint = v.swint; req_swnum = v.num;
        req_prio = v.prio; cur_u = v.u; cur_ipl = v.ipl;
        flg_in = f; pc_in = p; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Collect stack beats and the done pulse, starting at the current negedge.
    task automatic observe(input bit e_save, input bit e_sel, input logic [15:0] e_flg,
                           input logic [19:0] e_pc, input logic [2:0] e_ipl,
                           input string tag);
        int nwr = 0;
        bit fin = 0;
        logic [15:0] exp_d;
        string sel_tag = e_sel ? "R6" : (tag == "R9" ? "R9" : "R5");
        for (int w = 0; w < 40 && !fin; w++) begin
            if (stk_wr) begin
                case (nwr)
                    0:       exp_d = e_flg;
                    1:       exp_d = e_pc[15:0];
                    default: exp_d = {12'h0, e_pc[19:16]};
                endcase
                chk("R4", "slot", {30'd0, stk_slot}, nwr);
                chk("R4", "wdata", {16'd0, stk_wdata}, {16'd0, exp_d});
                chk(sel_tag, "stk_user", {31'd0, stk_user}, {31'd0, e_sel});
                nwr++;
            end else if (seq_done) begin
                chk(sel_tag, "new_u", {31'd0, new_u}, {31'd0, e_sel});
                chk(tag, "new_ipl", {29'd0, new_ipl}, {29'd0, e_ipl});
                chk("R7", "new_i/new_d", {30'd0, new_i, new_d}, 32'd0);
                fin = 1;
            end
            @(negedge clk);
        end
        chk(tag, "done seen", {31'd0, fin}, 32'd1);
        chk(e_save ? "R4" : "R9", "write count", nwr, e_save ? 32'd3 : 32'd0);
    endtask

    // Expect no activity for n negedges.
    task automatic quiet(input int n, input string req);
        int seen = 0;
        for (int k = 0; k < n; k++) begin
            if (stk_wr || seq_done) seen++;
            @(negedge clk);
        end
        chk(req, "no activity", seen, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "req_ready", {31'd0, req_ready}, 32'd1);
        chk("R1", "stk_wr", {31'd0, stk_wr}, 32'd0);
        chk("R1", "seq_done", {31'd0, seq_done}, 32'd0);

        // Table walk: R5 R6 R8 R9
        for (int i = 0; i < 10; i++) begin
            logic [15:0] f = 16'hA500 + 16'(i * 17);
            logic [19:0] p = 20'h31200 + 20'(i * 20'h1_0101);
            drive(VECS[i], f, p);
            observe(VECS[i].e_save, VECS[i].e_sel, f, p, VECS[i].e_ipl,
                    VECS[i].cls == 2'd0 ? "R9" : "R8");
        end

        // R2 / R3: short low pulse, core state looks fully masked
        cur_u = 1'b1; cur_ipl = 3'd7; flg_in = 16'h5A5A; pc_in = 20'hF_1234;
        nmi_pin = 1'b0;
        repeat (2) @(negedge clk);
        nmi_pin = 1'b1;
        observe(1'b1, 1'b0, 16'h5A5A, 20'hF_1234, 3'd7, "R3");
        quiet(20, "R2");   // rising edge starts nothing

        // R2: held low yields exactly one sequence
        flg_in = 16'h0F0F; pc_in = 20'h2_ABCD;
        nmi_pin = 1'b0;
        observe(1'b1, 1'b0, 16'h0F0F, 20'h2_ABCD, 3'd7, "R2");
        quiet(30, "R2");
        nmi_pin = 1'b1;
        quiet(10, "R2");

        // R10: request offered while busy is dropped
        drive('{2'd3, 1'b0, 6'd0, 3'd5, 1'b0, 3'd1, 1'b1, 1'b0, 3'd5}, 16'h1111, 20'h0_2222);
        req_class = 2'd0; req_valid = 1'b1;
        for (int k = 0; k < 4; k++) begin
            chk("R10", "ready while busy", {31'd0, req_ready}, 32'd0);
            if (k == 3) begin
                chk("R10", "done", {31'd0, seq_done}, 32'd1);
                chk("R10", "ipl of first", {29'd0, new_ipl}, 32'd5);
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        quiet(6, "R10");

        // R11: pin edge during busy plus held core request
        drive('{2'd1, 1'b0, 6'd0, 3'd0, 1'b0, 3'd2, 1'b1, 1'b0, 3'd7}, 16'h3333, 20'h1_4444);
        nmi_pin = 1'b0;
        req_class = 2'd3; req_prio = 3'd2; req_swint = 1'b0;
        cur_u = 1'b1; cur_ipl = 3'd4; flg_in = 16'h7777; pc_in = 20'h8_8888;
        req_valid = 1'b1;
        observe(1'b1, 1'b0, 16'h3333, 20'h1_4444, 3'd7, "R8");
        chk("R11", "ready with pending", {31'd0, req_ready}, 32'd0);
        observe(1'b1, 1'b0, 16'h7777, 20'h8_8888, 3'd7, "R11");
        chk("R11", "ready after nmi", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        nmi_pin = 1'b1;
        observe(1'b1, 1'b0, 16'h7777, 20'h8_8888, 3'd2, "R11");
        quiet(10, "R11");

        finish_run();
    end
endmodule